// File: doc/BRIEF.md
# External Memory Bus Controller

This block runs bus cycles on a multiplexed 16-bit external address/data bus for an internal CPU request port. The CPU presents a byte address, write data, a byte/word size, a read/write flag and an instruction-fetch flag. It holds its request until the block returns a one-clock done strobe with the read data. Externally the block drives an address strobe (latch-enable or address-valid style), read and write strobes, a byte-high/write-high pin and a fetch indicator. It samples a ready pin and a width pin, and it gives the bus to another master on a hold request between cycles.

The block clock runs at twice the oscillator rate, so one clock is one half oscillator period (a "tick"). Each byte or word cycle on the bus lasts eight ticks, numbered 0 to 7 from the edge that starts it, plus two ticks for each wait state. Wait ticks are inserted after tick 6, and the strobe stays active through them. Four timing modes shift the address strobe, the address drive and the read/write strobes within this frame. A word that cannot be moved in one cycle is split into two byte cycles, first at the request address and then at the address plus one. Configuration inputs are held stable during a transfer.

Top module: `ext_bus_ctrl`

## Requirements
- R1: In reset and when idle: ale_o low (high if adv_i=1), rd_n_o, wr_n_o and bhe_n_o high, inst_o, ad_oe_o, done_o and hlda_o low.
- R2: clkout_o is low for two ticks after reset, then alternates two ticks high and two ticks low, with a period of four ticks.
- R3: Standard mode (mode_i=3): ale_o is high in ticks 1-2, the address is driven on ad_o (ad_oe_o=1) in ticks 1-2, and the strobe is low in ticks 5-6. For a write, data is driven from tick 3 to the last strobe tick. Tick 7 ends the cycle with the strobes high.
- R4: Mode 0 (mode_i=0) has the standard timing, but the first wait state is always inserted, even when max_ws_i=0. That forced wait counts toward the cap.
- R5: Long-strobe mode (mode_i=1): ale_o is high in ticks 0-1 and the strobe is low in ticks 3-6. The address is driven in ticks 1-2.
- R6: Early-address mode (mode_i=2): strobe and ale_o as in R5, with the address driven in ticks 0-2.
- R7: ready_i is sampled on the edge that ends tick 6 and on the edge that ends each wait state. A low sample adds a two-tick wait only while the number of waits in that byte cycle is below max_ws_i.
- R8: Width is set by bw_cfg_i. 2'b11 takes buswidth_i at the start of the transfer (0 gives 8-bit, 1 gives 16-bit). 2'b01 gives 8-bit and 2'b10 gives 16-bit. 2'b00 raises cfg_err_o and runs 8-bit cycles.
- R9: On a 16-bit bus a word at an even address is one cycle with A0=0 and bhe_n_o=0. A byte sets A0 to its address bit and sets bhe_n_o to the inverse of that bit, on lane ad[15:8] for odd addresses and ad[7:0] for even ones. A word at an odd address, or any word on an 8-bit bus, takes two byte cycles. rdata_o[7:0] holds the byte at addr_i and rdata_o[15:8] holds the byte at addr_i+1 (0 for byte reads). Byte write data is copied to both lanes. done_o is high only in tick 7 of the last cycle.
- R10: With split_wr_i=0, wr_n_o is low for the strobe ticks of every write, and bhe_n_o gives the byte-high select for the whole 16-bit cycle (high in 8-bit cycles). With split_wr_i=1, wr_n_o pulses when the even byte is written, or on every 8-bit write, and bhe_n_o pulses when the odd byte is written in a 16-bit cycle.
- R11: With adv_i=1, ale_o is low from the tick where the address strobe would start through the last strobe or wait tick, and it is high in tick 7 and between cycles.
- R12: inst_o is high for the whole of a fetch read cycle, ticks 0-7 including waits, and low for writes and other reads.
- R13: A hold_i seen while idle, or at the end of a transfer, raises hlda_o on the next edge, and the bus stays quiet until hold_i falls. A hold during a transfer waits for it to finish. breq_o is high while req_i waits under hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the oscillator rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, held until done_o |
| addr_i | input | AW | Byte address |
| wdata_i | input | 16 | Write data, low byte at addr_i |
| word_i | input | 1 | 1 = word, 0 = byte |
| we_i | input | 1 | 1 = write |
| fetch_i | input | 1 | Instruction fetch |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | Transfer done strobe |
| mode_i | input | 2 | Timing mode 0..3 |
| bw_cfg_i | input | 2 | Width configuration |
| split_wr_i | input | 1 | Split write strobes |
| adv_i | input | 1 | Address-valid style address strobe |
| max_ws_i | input | WSW | Wait-state cap |
| clkout_o | output | 1 | Oscillator divided by two |
| ale_o | output | 1 | Address latch enable / address valid (low) |
| rd_n_o | output | 1 | Read strobe |
| wr_n_o | output | 1 | Write / write-low strobe |
| bhe_n_o | output | 1 | Byte high enable / write-high strobe |
| inst_o | output | 1 | Fetch indicator |
| ad_o | output | 16 | Address/data out |
| ad_oe_o | output | 1 | Address/data drive enable |
| ad_i | input | 16 | Address/data in |
| addr_hi_o | output | AW-16 | Upper address bits during a cycle |
| ready_i | input | 1 | Ready, low extends the cycle |
| buswidth_i | input | 1 | Width pin |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Hold acknowledge |
| breq_o | output | 1 | Request pending under hold |
| cfg_err_o | output | 1 | Illegal width configuration |

## Verification
The hardest case to reach is the interaction of the forced mode 0 wait with READY sampling and the cap. That case is driven by transfers in which READY is held low for a set number of samples, and the cap is set both below and above that number. The bench model consumes one READY sample per wait decision, so the number of inserted waits follows from the requirements alone. Hold is also raised partway through a transfer, to show that the grant waits for the final tick 7.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_HOLD = 2'd1, ST_RUN = 2'd2} bus_st_e;

  localparam logic [2:0] TK_STROBE_LAST = 3'd6;
  localparam logic [2:0] TK_END         = 3'd7;

  localparam logic [1:0] MODE_WAIT1   = 2'd0;
  localparam logic [1:0] MODE_LONG    = 2'd1;
  localparam logic [1:0] MODE_LONG_EA = 2'd2;

  typedef struct packed {
    logic two;     // transfer needs two byte cycles
    logic wcyc;    // single 16-bit word cycle
    logic lane;    // byte on ad[15:8]
    logic hi_sel;  // odd byte selected
    logic lo_sel;  // even byte selected (or 8-bit cycle)
  } lane_plan_t;
endpackage

// File: rtl/ext_bus_clkdiv.sv
module ext_bus_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clkout_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign clkout_o = cnt_q[DIV_W-1];
endmodule

// File: rtl/ext_bus_lanes.sv
module ext_bus_lanes
  import ext_bus_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] a_i,
  input  logic          word_i,
  input  logic          bus16_i,
  input  logic          part_i,
  input  logic [15:0]   wd_i,
  output logic [AW-1:0] ba_o,
  output lane_plan_t    plan_o,
  output logic [15:0]   dout_o
);
  logic [7:0] db;

  always_comb begin
    ba_o          = a_i + AW'(part_i);
    plan_o.two    = word_i && (!bus16_i || a_i[0]);
    plan_o.wcyc   = word_i && bus16_i && !a_i[0];
    plan_o.lane   = bus16_i && ba_o[0];
    plan_o.hi_sel = bus16_i && (plan_o.wcyc || ba_o[0]);
    plan_o.lo_sel = !bus16_i || plan_o.wcyc || !ba_o[0];
    db            = part_i ? wd_i[15:8] : wd_i[7:0];
    dout_o        = plan_o.wcyc ? wd_i : {db, db};
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int AW  = 20,
  parameter int WSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [15:0]    wdata_i,
  input  logic           word_i,
  input  logic           we_i,
  input  logic           fetch_i,
  input  logic [1:0]     mode_i,
  input  logic [1:0]     bw_cfg_i,
  input  logic [WSW-1:0] max_ws_i,
  input  logic           buswidth_i,
  input  logic           ready_i,
  input  logic           hold_i,
  input  logic [15:0]    ad_i,
  input  lane_plan_t     plan_i,
  output bus_st_e        st_o,
  output logic [2:0]     tick_o,
  output logic           wait_o,
  output logic           part_o,
  output logic [AW-1:0]  a_o,
  output logic [15:0]    wd_o,
  output logic           word_o,
  output logic           we_o,
  output logic           fetch_o,
  output logic           bus16_o,
  output logic [15:0]    rdata_o
);
  logic         wph_q;
  logic [WSW:0] ws_q;
  logic         need_wait;
  logic [7:0]   rbyte;

  assign need_wait = (mode_i == MODE_WAIT1 && ws_q == '0) ||
                     (!ready_i && ws_q < {1'b0, max_ws_i});
  assign rbyte = plan_i.lane ? ad_i[15:8] : ad_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= ST_IDLE; tick_o <= '0; wait_o <= 1'b0; wph_q <= 1'b0; ws_q <= '0;
      part_o <= 1'b0; a_o <= '0; wd_o <= '0; word_o <= 1'b0; we_o <= 1'b0;
      fetch_o <= 1'b0; bus16_o <= 1'b0; rdata_o <= '0;
    end else begin
      unique case (st_o)
        ST_IDLE: begin
          if (hold_i) st_o <= ST_HOLD;
          else if (req_i) begin
            st_o <= ST_RUN; tick_o <= '0; wait_o <= 1'b0; ws_q <= '0; part_o <= 1'b0;
            a_o <= addr_i; wd_o <= wdata_i; word_o <= word_i; we_o <= we_i;
            fetch_o <= fetch_i; rdata_o <= '0;
            bus16_o <= (bw_cfg_i == 2'b11) ? buswidth_i : (bw_cfg_i == 2'b10);
          end
        end
        ST_HOLD: if (!hold_i) st_o <= ST_IDLE;
        ST_RUN: begin
          if ((wait_o && wph_q) || (!wait_o && tick_o == TK_STROBE_LAST)) begin
            if (need_wait) begin
              wait_o <= 1'b1; wph_q <= 1'b0; ws_q <= ws_q + 1'b1;
            end else begin
              wait_o <= 1'b0; tick_o <= TK_END;
              if (plan_i.wcyc)  rdata_o <= ad_i;
              else if (part_o)  rdata_o[15:8] <= rbyte;
              else              rdata_o[7:0] <= rbyte;
            end
          end else if (wait_o) begin
            wph_q <= 1'b1;
          end else if (tick_o == TK_END) begin
            if (plan_i.two && !part_o) begin
              part_o <= 1'b1; tick_o <= '0; ws_q <= '0;
            end else begin
              st_o <= hold_i ? ST_HOLD : ST_IDLE;
            end
          end else begin
            tick_o <= tick_o + 3'd1;
          end
        end
        default: st_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ext_bus_pkg::*;
#(
  parameter int AW  = 20,
  parameter int WSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [15:0]    wdata_i,
  input  logic           word_i,
  input  logic           we_i,
  input  logic           fetch_i,
  output logic [15:0]    rdata_o,
  output logic           done_o,
  input  logic [1:0]     mode_i,
  input  logic [1:0]     bw_cfg_i,
  input  logic           split_wr_i,
  input  logic           adv_i,
  input  logic [WSW-1:0] max_ws_i,
  output logic           clkout_o,
  output logic           ale_o,
  output logic           rd_n_o,
  output logic           wr_n_o,
  output logic           bhe_n_o,
  output logic           inst_o,
  output logic [15:0]    ad_o,
  output logic           ad_oe_o,
  input  logic [15:0]    ad_i,
  output logic [AW-17:0] addr_hi_o,
  input  logic           ready_i,
  input  logic           buswidth_i,
  input  logic           hold_i,
  output logic           hlda_o,
  output logic           breq_o,
  output logic           cfg_err_o
);
  bus_st_e       st;
  logic [2:0]    tick;
  logic          wt, part, word_r, we_r, fetch_r, bus16;
  logic [AW-1:0] a_r, ba;
  logic [15:0]   wd_r, dout;
  lane_plan_t    plan;
  logic          m12, run, ale_w, adr_w, str_w, dat_w, adv_w;

  ext_bus_clkdiv #(.DIV_W(2)) u_clkdiv (.clk_i(clk_i), .rst_ni(rst_ni), .clkout_o(clkout_o));

  ext_bus_lanes #(.AW(AW)) u_lanes (
    .a_i(a_r), .word_i(word_r), .bus16_i(bus16), .part_i(part), .wd_i(wd_r),
    .ba_o(ba), .plan_o(plan), .dout_o(dout)
  );

  ext_bus_seq #(.AW(AW), .WSW(WSW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .word_i(word_i), .we_i(we_i), .fetch_i(fetch_i), .mode_i(mode_i), .bw_cfg_i(bw_cfg_i),
    .max_ws_i(max_ws_i), .buswidth_i(buswidth_i), .ready_i(ready_i), .hold_i(hold_i),
    .ad_i(ad_i), .plan_i(plan), .st_o(st), .tick_o(tick), .wait_o(wt), .part_o(part),
    .a_o(a_r), .wd_o(wd_r), .word_o(word_r), .we_o(we_r), .fetch_o(fetch_r),
    .bus16_o(bus16), .rdata_o(rdata_o)
  );

  always_comb begin
    m12   = (mode_i == MODE_LONG) || (mode_i == MODE_LONG_EA);
    run   = (st == ST_RUN);
    ale_w = run && !wt && (m12 ? (tick <= 3'd1) : (tick == 3'd1 || tick == 3'd2));
    adr_w = run && !wt && ((mode_i == MODE_LONG_EA) ? (tick <= 3'd2)
                                                    : (tick == 3'd1 || tick == 3'd2));
    str_w = run && (wt || (tick >= (m12 ? 3'd3 : 3'd5) && tick <= TK_STROBE_LAST));
    dat_w = run && we_r && (wt || (tick >= 3'd3 && tick <= TK_STROBE_LAST));
    adv_w = run && (wt || ((m12 || tick != 3'd0) && tick <= TK_STROBE_LAST));

    ale_o     = adv_i ? !adv_w : ale_w;
    rd_n_o    = !(str_w && !we_r);
    wr_n_o    = !(str_w && we_r && (!split_wr_i || plan.lo_sel));
    bhe_n_o   = split_wr_i ? !(str_w && we_r && plan.hi_sel) : !(run && plan.hi_sel);
    inst_o    = run && fetch_r && !we_r;
    ad_oe_o   = adr_w || dat_w;
    ad_o      = adr_w ? ba[15:0] : (dat_w ? dout : '0);
    addr_hi_o = run ? ba[AW-1:16] : '0;
    done_o    = run && !wt && tick == TK_END && (!plan.two || part);
    hlda_o    = (st == ST_HOLD);
    breq_o    = req_i && hlda_o;
    cfg_err_o = (bw_cfg_i == 2'b00);
  end
endmodule

// File: rtl/ext_bus_chk.sv
module ext_bus_chk #(
  parameter int WSW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rd_n_o,
  input logic           wr_n_o,
  input logic           ad_oe_o,
  input logic           inst_o,
  input logic           hlda_o,
  input logic           breq_o,
  input logic           done_o,
  input logic           clkout_o,
  input logic [WSW-1:0] max_ws_i
);
  logic       clk_prev;
  logic [2:0] clk_len;
  logic [7:0] rd_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev <= 1'b0; clk_len <= '0; rd_len <= '0;
    end else begin
      clk_prev <= clkout_o;
      clk_len  <= (clkout_o == clk_prev) ? clk_len + 3'd1 : 3'd1;
      rd_len   <= rd_n_o ? 8'd0 : rd_len + 8'd1;
    end
  end

  assert_clk_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_len <= 3'd2);
  assert_wait_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_len <= 8'd4 + 8'd2 * (8'(max_ws_i) + 8'd1));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  assert_inst_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_o |-> wr_n_o);
  assert_hold_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (rd_n_o && wr_n_o && !ad_oe_o && !inst_o && !done_o));
  assert_breq_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    breq_o |-> hlda_o);
endmodule

bind ext_bus_ctrl ext_bus_chk #(.WSW(WSW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o),
  .inst_o(inst_o), .hlda_o(hlda_o), .breq_o(breq_o), .done_o(done_o),
  .clkout_o(clkout_o), .max_ws_i(max_ws_i)
);

// File: tb/ext_bus_ctrl_bench.sv
`timescale 1ns/1ps
module ext_bus_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req = 0, word = 0, we = 0, fetch = 0, split = 0, adv = 0, pinw = 0;
  logic ready = 1, hold = 0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0, ad_in = '0;
  logic [1:0] mode = 2'd3, bw = 2'b10;
  logic [2:0] maxws = '0;
  logic [15:0] rdata, ad_out;
  logic done, clkout, ale, rd_n, wr_n, bhe_n, inst, ad_oe, hlda, breq, cfg_err;
  logic [3:0] addr_hi;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .word_i(word), .we_i(we), .fetch_i(fetch), .rdata_o(rdata), .done_o(done),
    .mode_i(mode), .bw_cfg_i(bw), .split_wr_i(split), .adv_i(adv), .max_ws_i(maxws),
    .clkout_o(clkout), .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .bhe_n_o(bhe_n),
    .inst_o(inst), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .addr_hi_o(addr_hi),
    .ready_i(ready), .buswidth_i(pinw), .hold_i(hold), .hlda_o(hlda), .breq_o(breq),
    .cfg_err_o(cfg_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    report();
  end

  function automatic logic [7:0] pins();
    return {ale, rd_n, wr_n, bhe_n, inst, ad_oe, done, hlda};
  endfunction

  // one transfer, checked tick by tick against the timeline of the requirements
  task automatic xfer(input string tag, input logic [19:0] a, input bit wd_w, input bit w_e,
                      input bit f, input logic [15:0] wd, input bit pw, input int nrdy,
                      input logic [15:0] r0, input logic [15:0] r1, input bit hmid);
    bit bus16, two, m12, wcyc;
    logic [15:0] erd;
    int nr;
    bus16 = (bw == 2'b11) ? pw : (bw == 2'b10);
    two   = wd_w && (!bus16 || a[0]);
    wcyc  = wd_w && bus16 && !a[0];
    m12   = (mode == 2'd1) || (mode == 2'd2);
    erd   = '0;
    nr    = nrdy;
    @(negedge clk);
    req = 1; addr = a; word = wd_w; we = w_e; fetch = f; wdata = wd; pinw = pw; ready = 1;
    @(posedge clk);
    for (int p = 0; p <= (two ? 1 : 0); p++) begin
      logic [19:0] ba;
      bit lane, hi, lo, inw, wph, last, str, adw, e_oe;
      int t, ws;
      logic [7:0] db, e;
      logic [15:0] rp, e_ad;
      ba = a + 20'(p);
      lane = bus16 && ba[0];
      hi = bus16 && (wcyc || ba[0]);
      lo = !bus16 || wcyc || !ba[0];
      last = (p == (two ? 1 : 0));
      rp = (p == 1) ? r1 : r0;
      ad_in = rp;
      db = (p == 1) ? wd[15:8] : wd[7:0];
      if (wcyc) erd = r0;
      else if (p == 1) erd[15:8] = lane ? rp[15:8] : rp[7:0];
      else erd[7:0] = lane ? rp[15:8] : rp[7:0];
      t = 0; inw = 0; wph = 0; ws = 0;
      forever begin
        @(negedge clk);
        str  = inw || (t >= (m12 ? 3 : 5) && t <= 6);
        adw  = !inw && t >= (mode == 2'd2 ? 0 : 1) && t <= 2;
        e_oe = adw || (w_e && (inw || (t >= 3 && t <= 6)));
        e[7] = adv ? !(inw || (t >= (m12 ? 0 : 1) && t <= 6))
                   : (!inw && t >= (m12 ? 0 : 1) && t <= (m12 ? 1 : 2));
        e[6] = !(str && !w_e);
        e[5] = !(str && w_e && (!split || lo));
        e[4] = split ? !(str && w_e && hi) : !hi;
        e[3] = f && !w_e;
        e[2] = e_oe;
        e[1] = (t == 7) && last;
        e[0] = 1'b0;
        chk(pins() == e, tag, 32'(pins()), 32'(e));
        e_ad = adw ? ba[15:0] : (wcyc ? wd : {db, db});
        if (e_oe) chk(ad_out == e_ad, tag, 32'(ad_out), 32'(e_ad));
        if (t == 0) chk(addr_hi == ba[19:16], tag, 32'(addr_hi), 32'(ba[19:16]));
        if (t == 7) begin
          if (last) begin
            if (!w_e) chk(rdata == erd, tag, 32'(rdata), 32'(erd));
            req = 0;
          end
          @(posedge clk);
          break;
        end
        if (hmid && p == 0 && t == 2 && !inw) hold = 1;
        if ((t == 6 && !inw) || (inw && wph)) begin
          bit lowr, need;
          lowr = (nr > 0);
          ready = !lowr;
          if (nr > 0) nr--;
          need = (mode == 2'd0 && ws == 0) || (lowr && ws < int'(maxws));
          if (need) begin ws++; inw = 1; wph = 0; end
          else begin inw = 0; t = 7; end
        end else if (inw) wph = 1;
        else t++;
        @(posedge clk);
      end
      ready = 1;
    end
  endtask

  initial begin
    logic v[12];
    int k0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pins() == 8'b0111_0000, "R1 in reset", 32'(pins()), 32'h70);
    rst_n = 1;
    @(negedge clk);
    chk(pins() == 8'b0111_0000, "R1 idle", 32'(pins()), 32'h70);
    chk(clkout == 1'b0, "R2 first", 32'(clkout), 0);
    for (int k = 0; k < 12; k++) begin v[k] = clkout; @(negedge clk); end
    k0 = 1;
    for (int k = 11; k >= 1; k--) if (v[k] != v[k-1]) k0 = k;
    for (int j = 0; j < 8; j++)
      chk(v[k0+j] == (v[k0] ^ 1'((j / 2) % 2)), "R2 period", 32'(v[k0+j]), 32'(v[k0] ^ 1'((j / 2) % 2)));

    xfer("R3 word read", 20'h31234, 1, 0, 0, 16'h0, 0, 0, 16'hBEEF, 16'h0, 0);
    xfer("R9 odd byte read", 20'h00101, 0, 0, 0, 16'h0, 0, 0, 16'hA55A, 16'h0, 0);
    xfer("R10 wr odd byte", 20'h00203, 0, 1, 0, 16'h0077, 0, 0, 16'h0, 16'h0, 0);
    xfer("R3 word write", 20'h00300, 1, 1, 0, 16'h9876, 0, 0, 16'h0, 16'h0, 0);
    split = 1;
    xfer("R10 split word", 20'h00400, 1, 1, 0, 16'h1234, 0, 0, 16'h0, 16'h0, 0);
    xfer("R10 split even", 20'h00402, 0, 1, 0, 16'h0056, 0, 0, 16'h0, 16'h0, 0);
    xfer("R10 split odd", 20'h00405, 0, 1, 0, 16'h0078, 0, 0, 16'h0, 16'h0, 0);
    split = 0;
    mode = 2'd0; maxws = 3'd0;
    xfer("R4 forced wait", 20'h00500, 1, 0, 0, 16'h0, 0, 0, 16'h1357, 16'h0, 0);
    maxws = 3'd3;
    xfer("R4 forced plus ready", 20'h00502, 1, 0, 0, 16'h0, 0, 2, 16'h2468, 16'h0, 0);
    mode = 2'd3; maxws = 3'd2;
    xfer("R7 capped", 20'h00504, 1, 0, 0, 16'h0, 0, 5, 16'h0F0F, 16'h0, 0);
    maxws = 3'd3;
    xfer("R7 one wait", 20'h00506, 0, 1, 0, 16'h00AA, 0, 1, 16'h0, 16'h0, 0);
    maxws = 3'd0;
    xfer("R7 cap zero", 20'h00508, 1, 0, 0, 16'h0, 0, 3, 16'h7777, 16'h0, 0);
    mode = 2'd1;
    xfer("R5 long read", 20'h00600, 1, 0, 0, 16'h0, 0, 0, 16'h4321, 16'h0, 0);
    mode = 2'd2;
    xfer("R6 early addr write", 20'h00610, 1, 1, 0, 16'hCAFE, 0, 0, 16'h0, 16'h0, 0);
    mode = 2'd3;
    bw = 2'b01;
    xfer("R8 8-bit word", 20'h00700, 1, 0, 0, 16'h0, 0, 0, 16'h0011, 16'h0022, 0);
    bw = 2'b11;
    xfer("R8 pin low", 20'h00710, 1, 0, 0, 16'h0, 0, 0, 16'h0033, 16'h0044, 0);
    xfer("R8 pin high", 20'h00720, 1, 0, 0, 16'h0, 1, 0, 16'h5566, 16'h0, 0);
    bw = 2'b00;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R8 illegal flag", 32'(cfg_err), 1);
    xfer("R8 illegal as 8-bit", 20'h00730, 1, 1, 0, 16'hB1B2, 0, 0, 16'h0, 16'h0, 0);
    bw = 2'b10;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R8 legal flag", 32'(cfg_err), 0);
    xfer("R9 misaligned read", 20'h00801, 1, 0, 0, 16'h0, 0, 0, 16'hAB00, 16'h00CD, 0);
    xfer("R9 misaligned write", 20'h00903, 1, 1, 0, 16'h5566, 0, 0, 16'h0, 16'h0, 0);
    adv = 1; maxws = 3'd1;
    xfer("R11 adv read", 20'h00A00, 1, 0, 0, 16'h0, 0, 1, 16'h2222, 16'h0, 0);
    mode = 2'd1;
    xfer("R11 adv long write", 20'h00A10, 0, 1, 0, 16'h0031, 0, 0, 16'h0, 16'h0, 0);
    mode = 2'd3; adv = 0; maxws = 3'd0;
    @(negedge clk);
    chk(ale == 1'b0, "R1 idle ale", 32'(ale), 0);
    xfer("R12 fetch", 20'h00B00, 1, 0, 1, 16'h0, 0, 0, 16'h6789, 16'h0, 0);
    xfer("R12 fetch flag on write", 20'h00B10, 1, 1, 1, 16'h1111, 0, 0, 16'h0, 16'h0, 0);

    @(negedge clk); hold = 1;
    @(negedge clk);
    chk(hlda == 1'b1, "R13 grant", 32'(hlda), 1);
    req = 1; addr = 20'h00C00; word = 1; we = 0; fetch = 0;
    repeat (3) begin
      @(negedge clk);
      chk(pins() == 8'b0111_0001, "R13 quiet", 32'(pins()), 32'h71);
      chk(breq == 1'b1, "R13 breq", 32'(breq), 1);
    end
    req = 0; hold = 0;
    @(negedge clk);
    chk(hlda == 1'b0 && breq == 1'b0, "R13 release", 32'({hlda, breq}), 0);
    xfer("R13 hold mid cycle", 20'h00C10, 1, 0, 0, 16'h0, 0, 0, 16'h3C3C, 16'h0, 1);
    @(negedge clk);
    chk(hlda == 1'b1, "R13 grant after cycle", 32'(hlda), 1);
    hold = 0;
    @(negedge clk);
    chk(hlda == 1'b0, "R13 drop", 32'(hlda), 0);
    report();
  end
endmodule